// File: doc/BRIEF.md
# Receive Frame Tracker

This block sits between a byte-wide receive stream and a frame data memory. Every byte the stream presents with its valid strobe goes into the memory at the next sequential address. The block also follows the frame boundaries given by the start and end strobes. It flags the memory write that carries the first byte of each frame. It measures each frame's length and keeps a running total of closed frames.

When a frame closes, the block writes a descriptor to a separate table. The descriptor holds the memory address of the frame's first byte and the frame's length in bytes. The table slot used is the number of frames closed before this one. Downstream logic uses the table to find each frame in memory without parsing the stream again.

Top module: `rx_frame_tracker`

## Requirements
- R1: Each byte accepted with `rx_valid_i` high appears on the memory write port on the next cycle with unchanged data. Addresses start at 0 after reset, rise by one per accepted byte and wrap from MEM_DEPTH-1 to 0. `mem_we_o` is low on the cycle after a cycle with no valid byte.
- R2: `mem_first_o` is high exactly on the memory writes of bytes accepted with `rx_sof_i` high.
- R3: A frame's length counts the accepted bytes from its start byte to its end byte, both ends included, and saturates at 2^LEN_W-1.
- R4: A descriptor write (`desc_we_o` high) comes one cycle after the byte that closes a frame. It carries the frame's start address and its length. Its index `desc_idx_o` equals the frame count before that frame was added.
- R5: `frame_cnt_o` rises by one for each closed frame, in the cycle of its descriptor event, and saturates at 2^CNT_W-1. Descriptor indices saturate with it.
- R6: A start byte that arrives while a frame is open closes the open frame. That frame's length counts only the bytes before the new start byte.
- R7: A byte with both start and end strobes that arrives while a frame is open produces two descriptors on consecutive cycles. The truncated frame comes first, on the next cycle. The one-byte frame follows one cycle later.
- R8: Bytes that arrive while no frame is open and carry no start strobe are written to memory. They cause no descriptor write and no count change.
- R9: Asserting `rst_ni` low clears the write address, the frame count, the open-frame state and the descriptor strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte present this cycle |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| rx_data_i | input | DATA_W | Received byte |
| mem_we_o | output | 1 | Frame memory write enable |
| mem_first_o | output | 1 | Write carries a frame's first byte |
| mem_addr_o | output | ADDR_W | Frame memory write address |
| mem_data_o | output | DATA_W | Frame memory write data |
| desc_we_o | output | 1 | Descriptor table write enable |
| desc_idx_o | output | CNT_W | Descriptor table slot |
| desc_start_o | output | ADDR_W | Frame start address |
| desc_len_o | output | LEN_W | Frame length in bytes |
| frame_cnt_o | output | CNT_W | Number of frames closed |

## Verification
Two frame closures can fall on the same input byte. This happens when a byte carrying both start and end strobes arrives while a frame is still open: the byte truncates the open frame and forms a one-byte frame of its own. The stimulus table provokes this twice. The second time, another one-byte frame follows directly, so the deferred descriptor and a new closure compete for the same cycle. The bench judges the pair by the order of the descriptors, their indices, their start addresses and the count advancing by two in one cycle.

// File: rtl/rxft_pkg.sv
package rxft_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_OPEN = 1'b1
  } frame_state_e;
endpackage

// File: rtl/rxft_wr_path.sv
module rxft_wr_path #(
  parameter int DATA_W    = 8,
  parameter int MEM_DEPTH = 64,
  localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic              mem_we_o,
  output logic              mem_first_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(MEM_DEPTH - 1);

  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (valid_i) ptr_d = (ptr_q == LAST_ADDR) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      mem_we_o    <= 1'b0;
      mem_first_o <= 1'b0;
      mem_addr_o  <= '0;
      mem_data_o  <= '0;
    end else begin
      ptr_q       <= ptr_d;
      mem_we_o    <= valid_i;
      mem_first_o <= valid_i & sof_i;
      if (valid_i) begin
        mem_addr_o <= ptr_q;
        mem_data_o <= data_i;
      end
    end
  end

  assign wr_ptr_o = ptr_q;
endmodule

// File: rtl/rxft_frame_meas.sv
module rxft_frame_meas
  import rxft_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [ADDR_W-1:0] wr_ptr_i,
  // closure of the frame that was open before this byte
  output logic              old_close_o,
  output logic [ADDR_W-1:0] old_start_o,
  output logic [LEN_W-1:0]  old_len_o,
  // one-byte frame formed by this byte
  output logic              new_close_o,
  output logic [ADDR_W-1:0] new_start_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  frame_state_e      state_q;
  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  len_q, len_inc;
  logic              is_open;

  assign is_open = (state_q == FS_OPEN);
  assign len_inc = (len_q == LEN_MAX) ? LEN_MAX : len_q + 1'b1;

  assign old_close_o = valid_i & is_open & (sof_i | eof_i);
  assign old_start_o = start_q;
  assign old_len_o   = sof_i ? len_q : len_inc;
  assign new_close_o = valid_i & sof_i & eof_i;
  assign new_start_o = wr_ptr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      start_q <= '0;
      len_q   <= '0;
    end else if (valid_i) begin
      if (sof_i) begin
        state_q <= eof_i ? FS_IDLE : FS_OPEN;
        start_q <= wr_ptr_i;
        len_q   <= LEN_W'(1);
      end else if (is_open) begin
        len_q <= len_inc;
        if (eof_i) state_q <= FS_IDLE;
      end
    end
  end
endmodule

// File: rtl/rxft_desc_emit.sv
module rxft_desc_emit #(
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              old_close_i,
  input  logic [ADDR_W-1:0] old_start_i,
  input  logic [LEN_W-1:0]  old_len_i,
  input  logic              new_close_i,
  input  logic [ADDR_W-1:0] new_start_i,
  output logic              desc_we_o,
  output logic [CNT_W-1:0]  desc_idx_o,
  output logic [ADDR_W-1:0] desc_start_o,
  output logic [LEN_W-1:0]  desc_len_o,
  output logic [CNT_W-1:0]  frame_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef struct packed {
    logic [CNT_W-1:0]  idx;
    logic [ADDR_W-1:0] start;
    logic [LEN_W-1:0]  len;
  } desc_t;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? CNT_MAX : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_d;
  logic             pend_vld_q, pend_vld_d;
  desc_t            pend_q, pend_d;
  desc_t            old_desc, new_desc, out_desc;
  logic             out_vld;

  // older closure takes the lower index
  assign cnt_mid  = old_close_i ? sat_inc(cnt_q) : cnt_q;
  assign cnt_d    = new_close_i ? sat_inc(cnt_mid) : cnt_mid;
  assign old_desc = '{idx: cnt_q,   start: old_start_i, len: old_len_i};
  assign new_desc = '{idx: cnt_mid, start: new_start_i, len: LEN_W'(1)};

  // at most two entries compete; a held entry implies no open frame
  always_comb begin
    out_vld    = 1'b0;
    out_desc   = old_desc;
    pend_vld_d = 1'b0;
    pend_d     = pend_q;
    if (pend_vld_q) begin
      out_vld  = 1'b1;
      out_desc = pend_q;
      if (old_close_i) begin
        pend_vld_d = 1'b1;
        pend_d     = old_desc;
      end else if (new_close_i) begin
        pend_vld_d = 1'b1;
        pend_d     = new_desc;
      end
    end else if (old_close_i) begin
      out_vld  = 1'b1;
      out_desc = old_desc;
      if (new_close_i) begin
        pend_vld_d = 1'b1;
        pend_d     = new_desc;
      end
    end else if (new_close_i) begin
      out_vld  = 1'b1;
      out_desc = new_desc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      pend_vld_q   <= 1'b0;
      pend_q       <= '0;
      desc_we_o    <= 1'b0;
      desc_idx_o   <= '0;
      desc_start_o <= '0;
      desc_len_o   <= '0;
    end else begin
      cnt_q      <= cnt_d;
      pend_vld_q <= pend_vld_d;
      pend_q     <= pend_d;
      desc_we_o  <= out_vld;
      if (out_vld) begin
        desc_idx_o   <= out_desc.idx;
        desc_start_o <= out_desc.start;
        desc_len_o   <= out_desc.len;
      end
    end
  end

  assign frame_cnt_o = cnt_q;
endmodule

// File: rtl/rx_frame_tracker.sv
module rx_frame_tracker #(
  parameter int DATA_W    = 8,
  parameter int MEM_DEPTH = 64,
  parameter int LEN_W     = 12,
  parameter int CNT_W     = 8,
  localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              mem_we_o,
  output logic              mem_first_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              desc_we_o,
  output logic [CNT_W-1:0]  desc_idx_o,
  output logic [ADDR_W-1:0] desc_start_o,
  output logic [LEN_W-1:0]  desc_len_o,
  output logic [CNT_W-1:0]  frame_cnt_o
);
  logic [ADDR_W-1:0] wr_ptr;
  logic              old_close, new_close;
  logic [ADDR_W-1:0] old_start, new_start;
  logic [LEN_W-1:0]  old_len;

  rxft_wr_path #(.DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)) u_wr (
    .clk_i, .rst_ni,
    .valid_i    (rx_valid_i),
    .sof_i      (rx_sof_i),
    .data_i     (rx_data_i),
    .wr_ptr_o   (wr_ptr),
    .mem_we_o,
    .mem_first_o,
    .mem_addr_o,
    .mem_data_o
  );

  rxft_frame_meas #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_meas (
    .clk_i, .rst_ni,
    .valid_i     (rx_valid_i),
    .sof_i       (rx_sof_i),
    .eof_i       (rx_eof_i),
    .wr_ptr_i    (wr_ptr),
    .old_close_o (old_close),
    .old_start_o (old_start),
    .old_len_o   (old_len),
    .new_close_o (new_close),
    .new_start_o (new_start)
  );

  rxft_desc_emit #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_emit (
    .clk_i, .rst_ni,
    .old_close_i (old_close),
    .old_start_i (old_start),
    .old_len_i   (old_len),
    .new_close_i (new_close),
    .new_start_i (new_start),
    .desc_we_o,
    .desc_idx_o,
    .desc_start_o,
    .desc_len_o,
    .frame_cnt_o
  );
endmodule

// File: rtl/rx_frame_tracker_chk.sv
module rx_frame_tracker_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic              rx_sof_i,
  input logic              rx_eof_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              mem_we_o,
  input logic              mem_first_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_o,
  input logic              desc_we_o,
  input logic [CNT_W-1:0]  desc_idx_o,
  input logic [ADDR_W-1:0] desc_start_o,
  input logic [LEN_W-1:0]  desc_len_o,
  input logic [CNT_W-1:0]  frame_cnt_o
);
  logic              seen_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (mem_we_o) begin
      seen_q <= 1'b1;
      last_q <= mem_addr_o;
    end
  end

  // R1 (default depth is a power of two, so wrap is modular)
  a_r1_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && seen_q |-> mem_addr_o == last_q + 1'b1);

  a_r2_first_is_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_first_o |-> mem_we_o);

  a_r3_len_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_we_o |-> desc_len_o != '0);

  a_r4_desc_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_we_o |-> ($past(rx_valid_i) && ($past(rx_sof_i) || $past(rx_eof_i)))
                  || $past(desc_we_o));

  a_r5_cnt_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rx_valid_i) |-> frame_cnt_o == $past(frame_cnt_o));

  a_r5_cnt_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_cnt_o >= $past(frame_cnt_o));
endmodule

bind rx_frame_tracker rx_frame_tracker_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/rx_frame_tracker_tb_top.sv
module rx_frame_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8, MEM_DEPTH = 64, LEN_W = 12, CNT_W = 8;
  localparam int ADDR_W = $clog2(MEM_DEPTH);
  localparam int NVEC = 16;

  typedef struct packed {
    logic       v, s, e;
    logic [7:0] d;
    logic       mwe, mf;
    logic [5:0] ma;
    logic       dwe;
    logic [7:0] di;
    logic [5:0] ds;
    logic [11:0] dl;
    logic [7:0] cnt;
  } vec_t;

  // v s e data | mwe first addr | dwe idx start len | cnt
  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b1,1'b0,8'h11, 1'b1,1'b1,6'd0,  1'b0,8'd0,6'd0,12'd0, 8'd0},
    '{1'b1,1'b0,1'b0,8'h22, 1'b1,1'b0,6'd1,  1'b0,8'd0,6'd0,12'd0, 8'd0},
    '{1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,6'd0,  1'b0,8'd0,6'd0,12'd0, 8'd0},
    '{1'b1,1'b0,1'b1,8'h33, 1'b1,1'b0,6'd2,  1'b1,8'd0,6'd0,12'd3, 8'd1},
    '{1'b1,1'b1,1'b1,8'h44, 1'b1,1'b1,6'd3,  1'b1,8'd1,6'd3,12'd1, 8'd2},
    '{1'b1,1'b1,1'b0,8'h55, 1'b1,1'b1,6'd4,  1'b0,8'd0,6'd0,12'd0, 8'd2},
    '{1'b1,1'b0,1'b0,8'h66, 1'b1,1'b0,6'd5,  1'b0,8'd0,6'd0,12'd0, 8'd2},
    '{1'b1,1'b1,1'b0,8'h77, 1'b1,1'b1,6'd6,  1'b1,8'd2,6'd4,12'd2, 8'd3},  // R6
    '{1'b1,1'b1,1'b1,8'h88, 1'b1,1'b1,6'd7,  1'b1,8'd3,6'd6,12'd1, 8'd5},  // R7
    '{1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,6'd0,  1'b1,8'd4,6'd7,12'd1, 8'd5},  // R7 deferred
    '{1'b1,1'b0,1'b1,8'h99, 1'b1,1'b0,6'd8,  1'b0,8'd0,6'd0,12'd0, 8'd5},  // R8 stray
    '{1'b1,1'b1,1'b0,8'hAA, 1'b1,1'b1,6'd9,  1'b0,8'd0,6'd0,12'd0, 8'd5},
    '{1'b1,1'b1,1'b1,8'hBB, 1'b1,1'b1,6'd10, 1'b1,8'd5,6'd9,12'd1, 8'd7},
    '{1'b1,1'b1,1'b1,8'hCC, 1'b1,1'b1,6'd11, 1'b1,8'd6,6'd10,12'd1,8'd8},
    '{1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,6'd0,  1'b1,8'd7,6'd11,12'd1,8'd8},
    '{1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,6'd0,  1'b0,8'd0,6'd0,12'd0, 8'd8}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rx_valid_i = 1'b0, rx_sof_i = 1'b0, rx_eof_i = 1'b0;
  logic [DATA_W-1:0] rx_data_i = '0;
  logic              mem_we_o, mem_first_o, desc_we_o;
  logic [ADDR_W-1:0] mem_addr_o, desc_start_o;
  logic [DATA_W-1:0] mem_data_o;
  logic [CNT_W-1:0]  desc_idx_o, frame_cnt_o;
  logic [LEN_W-1:0]  desc_len_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rx_frame_tracker #(.DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) dut_i (
    .clk_i, .rst_ni, .rx_valid_i, .rx_sof_i, .rx_eof_i, .rx_data_i,
    .mem_we_o, .mem_first_o, .mem_addr_o, .mem_data_o,
    .desc_we_o, .desc_idx_o, .desc_start_o, .desc_len_o, .frame_cnt_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 time unit after the rising edge
  task automatic step(input logic v, input logic s, input logic e, input logic [7:0] d);
    @(negedge clk_i);
    rx_valid_i = v; rx_sof_i = s; rx_eof_i = e; rx_data_i = d;
    @(posedge clk_i);
    #1;
  endtask

  function automatic string desc_tag(input int i);
    if (i == 7) return "R6";
    if (i == 8 || i == 9 || i == 12 || i == 13 || i == 14) return "R7";
    if (i == 10) return "R8";
    return "R4";
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R9 reset state
    chk("R9", "mem_we", int'(mem_we_o), 0);
    chk("R9", "desc_we", int'(desc_we_o), 0);
    chk("R9", "frame_cnt", int'(frame_cnt_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      vec_t t;
      t = VECS[i];
      step(t.v, t.s, t.e, t.d);
      chk("R1", $sformatf("v%0d mem_we", i), int'(mem_we_o), int'(t.mwe));
      if (t.mwe) begin
        chk("R1", $sformatf("v%0d addr", i), int'(mem_addr_o), int'(t.ma));
        chk("R1", $sformatf("v%0d data", i), int'(mem_data_o), int'(t.d));
        chk("R2", $sformatf("v%0d first", i), int'(mem_first_o), int'(t.mf));
      end
      chk(desc_tag(i), $sformatf("v%0d desc_we", i), int'(desc_we_o), int'(t.dwe));
      if (t.dwe) begin
        chk(desc_tag(i), $sformatf("v%0d idx", i), int'(desc_idx_o), int'(t.di));
        chk(desc_tag(i), $sformatf("v%0d start", i), int'(desc_start_o), int'(t.ds));
        chk(desc_tag(i), $sformatf("v%0d len", i), int'(desc_len_o), int'(t.dl));
      end
      chk("R5", $sformatf("v%0d cnt", i), int'(frame_cnt_o), int'(t.cnt));
    end

    // R1 wrap and R3 length: 70-byte frame from address 12
    for (int k = 0; k < 70; k++) begin
      step(1'b1, k == 0, k == 69, 8'(k));
      chk("R1", "wrap addr", int'(mem_addr_o), (12 + k) % MEM_DEPTH);
      if (k < 69) chk("R4", "no early desc", int'(desc_we_o), 0);
    end
    chk("R4", "long desc_we", int'(desc_we_o), 1);
    chk("R3", "long len", int'(desc_len_o), 70);
    chk("R4", "long start", int'(desc_start_o), 12);
    chk("R4", "long idx", int'(desc_idx_o), 8);
    chk("R5", "long cnt", int'(frame_cnt_o), 9);

    // R5 saturation: 250 one-byte frames push the count past 255
    for (int k = 0; k < 250; k++) step(1'b1, 1'b1, 1'b1, 8'hF0);
    chk("R5", "sat cnt", int'(frame_cnt_o), 255);
    chk("R5", "sat idx", int'(desc_idx_o), 255);
    chk("R5", "sat start", int'(desc_start_o), (18 + 249) % MEM_DEPTH);

    // R3 length saturation at 4095
    for (int k = 0; k < 4100; k++) step(1'b1, k == 0, k == 4099, 8'h5C);
    chk("R3", "sat len", int'(desc_len_o), 4095);
    chk("R3", "sat len we", int'(desc_we_o), 1);

    // R9 mid-stream reset
    step(1'b1, 1'b1, 1'b0, 8'h01);
    @(negedge clk_i);
    rst_ni = 1'b0; rx_valid_i = 1'b0;
    @(posedge clk_i);
    #1;
    chk("R9", "cnt after reset", int'(frame_cnt_o), 0);
    chk("R9", "desc_we after reset", int'(desc_we_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b1, 1'b0, 1'b1, 8'h02);
    chk("R9", "no open frame after reset", int'(desc_we_o), 0);
    chk("R9", "addr after reset", int'(mem_addr_o), 0);
    step(1'b1, 1'b1, 1'b1, 8'h5A);
    chk("R9", "first frame start", int'(desc_start_o), 1);
    chk("R9", "first frame idx", int'(desc_idx_o), 0);
    chk("R9", "count restarts", int'(frame_cnt_o), 1);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    chk("R1", "idle no write", int'(mem_we_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule